// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

A purely combinational adder for two N-bit operands plus a carry-in, with N a power of two. The operands first become per-bit generate (both bits one) and propagate (bits differ) terms. The carry-in is merged into the generate term of bit 0. A log-depth network of valency-2 prefix cells then forms, for every bit position, the carry out of the span from that bit down to the carry-in. The sums are the propagate terms XORed with the carry into each bit. The carry-out is the prefix over the whole word.

One enumerated parameter picks the shape of the prefix network:

- **Kogge-Stone:** log2 N stages, fanout 2 and about N·log2 N cells.
- **Sklansky:** log2 N stages, fanout up to N/2+1 and about half that many cells.
- **Brent-Kung:** 2·log2 N − 1 stages, fanout 2 and the fewest cells.

A node whose span already reaches the carry-in needs only its generate output, so it is built as a generate-only (grey) cell. Every other combining node is a full (black) cell.

Top module: `ppAdder`

## Requirements
- R1: `sumOut` equals the low N bits of opA + opB + carryIn for every input combination.
- R2: `carryOut` equals bit N of the (N+1)-bit sum opA + opB + carryIn.
- R3: The carry-in enters only at bit 0. With opA = opB = 0, `sumOut` equals carryIn (value 1 or 0 in bit 0, zeros above) and `carryOut` is 0.
- R4: The all-propagate case has opA XOR opB equal to all ones. In that case `carryOut` equals carryIn, and `sumOut` is all ones when carryIn = 0 and all zeros when carryIn = 1.
- R5: The all-generate case has opA = opB = all ones. In that case `carryOut` is 1, `sumOut` bit 0 equals carryIn, and all other sum bits are 1.
- R6: `TOPO` encodes the network shape: 0 = Kogge-Stone, 1 = Sklansky, 2 = Brent-Kung. All three settings give identical, correct results on the same random operands.
- R7: At N = 4 and N = 8, every topology is correct on all operand and carry-in combinations.
- R8: With all inputs zero, `sumOut` and `carryOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | N | First operand |
| opB | input | N | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | N | Low N bits of the sum |
| carryOut | output | 1 | Carry out of bit N-1 |

## Verification
Carry-in folding and the longest prefix chain act together when the operands are exact complements and carryIn is 1. The folded bit-0 generate must then travel through every stage of the network to every sum bit and to carryOut. The bench provokes this with several complement pairs on all three topologies side by side. It judges the result against an arithmetic sum computed in the bench: all-zero sum and carry-out equal to the carry-in. The exhaustive sweeps at N = 4 and N = 8 cover the same collision for every partial propagate run.

// File: rtl/ppAdderPkg.sv
package ppAdderPkg;

  typedef enum logic [1:0] {
    TOPO_KOGGE_STONE = 2'd0,
    TOPO_SKLANSKY    = 2'd1,
    TOPO_BRENT_KUNG  = 2'd2
  } topoT;

  // Number of prefix stages for a word of 2**lg bits.
  function automatic int numStages(topoT t, int lg);
    if (t == TOPO_BRENT_KUNG) return (2 * lg) - 1;
    return lg;
  endfunction

  // Index of the lower operand combined into node i at stage s, or -1 for a wire.
  function automatic int partnerOf(topoT t, int lg, int s, int i);
    int d;
    int l;
    case (t)
      TOPO_SKLANSKY: begin
        d = 1 << (s - 1);
        if ((i & d) != 0) return ((i >> (s - 1)) << (s - 1)) - 1;
        return -1;
      end
      TOPO_BRENT_KUNG: begin
        if (s <= lg) begin
          if (((i + 1) % (1 << s)) == 0) return i - (1 << (s - 1));
          return -1;
        end
        l = (2 * lg) - s;
        d = 1 << (l - 1);
        if ((((i + 1) % (1 << l)) == d) && (i >= (1 << l))) return i - d;
        return -1;
      end
      default: begin
        d = 1 << (s - 1);
        if (i >= d) return i - d;
        return -1;
      end
    endcase
  endfunction

  // A node whose combined span reaches the carry-in only needs a generate output.
  function automatic bit isGreyNode(topoT t, int lg, int s, int i);
    if (t == TOPO_BRENT_KUNG) begin
      if (s <= lg) return (i == ((1 << s) - 1));
      return 1'b1;
    end
    return (i < (1 << s));
  endfunction

endpackage

// File: rtl/pgInit.sv
module pgInit #(
  parameter int N = 32
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         carryIn,
  output logic [N-1:0] gBit,
  output logic [N-1:0] pBit
);
  logic [N-1:0] gRaw;

  assign pBit = opA ^ opB;
  assign gRaw = opA & opB;

  // Fold the carry-in into the generate term of bit 0.
  if (N > 1) begin : wide
    assign gBit = {gRaw[N-1:1], gRaw[0] | (pBit[0] & carryIn)};
  end else begin : narrow
    assign gBit = gRaw[0] | (pBit[0] & carryIn);
  end
endmodule

// File: rtl/prefixTree.sv
module prefixTree
  import ppAdderPkg::*;
#(
  parameter int   N    = 32,
  parameter topoT TOPO = TOPO_KOGGE_STONE
) (
  input  logic [N-1:0] gIn,
  input  logic [N-1:0] pIn,
  output logic [N-1:0] gPre
);
  localparam int LG     = $clog2(N);
  localparam int STAGES = numStages(TOPO, LG);

  for (genvar s = 0; s <= STAGES; s++) begin : stage
    logic [N-1:0] gV;
    logic [N-1:0] pV;
    if (s == 0) begin : seed
      assign gV = gIn;
      assign pV = pIn;
    end else begin : build
      for (genvar i = 0; i < N; i++) begin : node
        localparam int J    = partnerOf(TOPO, LG, s, i);
        localparam bit GREY = isGreyNode(TOPO, LG, s, i);
        if (J < 0) begin : wire_through
          assign gV[i] = stage[s-1].gV[i];
          assign pV[i] = stage[s-1].pV[i];
        end else if (GREY) begin : grey_cell
          assign gV[i] = stage[s-1].gV[i] | (stage[s-1].pV[i] & stage[s-1].gV[J]);
          assign pV[i] = stage[s-1].pV[i];
        end else begin : black_cell
          assign gV[i] = stage[s-1].gV[i] | (stage[s-1].pV[i] & stage[s-1].gV[J]);
          assign pV[i] = stage[s-1].pV[i] & stage[s-1].pV[J];
        end
      end
    end
  end

  assign gPre = stage[STAGES].gV;

  logic unusedLastP;
  assign unusedLastP = ^stage[STAGES].pV;
endmodule

// File: rtl/sumStage.sv
module sumStage #(
  parameter int N = 32
) (
  input  logic [N-1:0] pBit,
  input  logic [N-1:0] carryVec,
  output logic [N-1:0] sumOut
);
  assign sumOut = pBit ^ carryVec;
endmodule

// File: rtl/ppAdder.sv
module ppAdder
  import ppAdderPkg::*;
#(
  parameter int   N    = 32,
  parameter topoT TOPO = TOPO_KOGGE_STONE
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         carryIn,
  output logic [N-1:0] sumOut,
  output logic         carryOut
);
  logic [N-1:0] gBit;
  logic [N-1:0] pBit;
  logic [N-1:0] gPre;
  logic [N-1:0] carryVec;

  pgInit #(.N(N)) uPg (
    .opA(opA), .opB(opB), .carryIn(carryIn), .gBit(gBit), .pBit(pBit)
  );

  prefixTree #(.N(N), .TOPO(TOPO)) uTree (
    .gIn(gBit), .pIn(pBit), .gPre(gPre)
  );

  if (N > 1) begin : carryWide
    assign carryVec = {gPre[N-2:0], carryIn};
  end else begin : carryNarrow
    assign carryVec = carryIn;
  end

  assign carryOut = gPre[N-1];

  sumStage #(.N(N)) uSum (
    .pBit(pBit), .carryVec(carryVec), .sumOut(sumOut)
  );
endmodule

// File: rtl/ppAdderChk.sv
module ppAdderChk #(
  parameter int N = 32
) (
  input logic [N-1:0] opA,
  input logic [N-1:0] opB,
  input logic         carryIn,
  input logic [N-1:0] sumOut,
  input logic         carryOut,
  input logic [N-1:0] carryVec
);
  logic [N:0]   refTotal;
  logic [N-1:0] refCarry;
  logic         known;

  always_comb begin
    refTotal = {1'b0, opA} + {1'b0, opB} + {{N{1'b0}}, carryIn};
    refCarry = refTotal[N-1:0] ^ opA ^ opB;
    known    = !$isunknown({opA, opB, carryIn});
    if (known) begin
      assert_sum_R1: assert (sumOut == refTotal[N-1:0]);
      assert_carry_out_R2: assert (carryOut == refTotal[N]);
      // R1: internal carries agree with the arithmetic carries into each bit
      assert_prefix_carries_R1: assert (carryVec == refCarry);
      if ((opA == '0) && (opB == '0)) begin
        assert_cin_only_R3: assert ((sumOut == {{(N-1){1'b0}}, carryIn}) && !carryOut);
      end
      if ((opA ^ opB) == '1) begin
        assert_all_propagate_R4: assert ((carryOut == carryIn) && (sumOut == {N{~carryIn}}));
      end
      if ((opA == '1) && (opB == '1)) begin
        assert_all_generate_R5: assert (carryOut && (sumOut[0] == carryIn));
      end
    end
  end
endmodule

bind ppAdder ppAdderChk #(.N(N)) uChk (
  .opA(opA), .opB(opB), .carryIn(carryIn),
  .sumOut(sumOut), .carryOut(carryOut), .carryVec(carryVec)
);

// File: tb/sim_ppAdder.sv
module sim_ppAdder;
  import ppAdderPkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checksRun  = 0;
  int checksFail = 0;

  logic [31:0] a32, b32;
  logic        c32;
  logic [31:0] sK32, sS32, sB32;
  logic        oK32, oS32, oB32;

  logic [3:0] a4, b4;
  logic       c4;
  logic [3:0] sK4, sS4, sB4;
  logic       oK4, oS4, oB4;

  logic [7:0] a8, b8;
  logic       c8;
  logic [7:0] sK8, sS8, sB8;
  logic       oK8, oS8, oB8;

  ppAdder #(.N(32), .TOPO(TOPO_KOGGE_STONE)) u0 (.opA(a32), .opB(b32), .carryIn(c32), .sumOut(sK32), .carryOut(oK32));
  ppAdder #(.N(32), .TOPO(TOPO_SKLANSKY))    u1 (.opA(a32), .opB(b32), .carryIn(c32), .sumOut(sS32), .carryOut(oS32));
  ppAdder #(.N(32), .TOPO(TOPO_BRENT_KUNG))  u2 (.opA(a32), .opB(b32), .carryIn(c32), .sumOut(sB32), .carryOut(oB32));
  ppAdder #(.N(4),  .TOPO(TOPO_KOGGE_STONE)) u3 (.opA(a4), .opB(b4), .carryIn(c4), .sumOut(sK4), .carryOut(oK4));
  ppAdder #(.N(4),  .TOPO(TOPO_SKLANSKY))    u4 (.opA(a4), .opB(b4), .carryIn(c4), .sumOut(sS4), .carryOut(oS4));
  ppAdder #(.N(4),  .TOPO(TOPO_BRENT_KUNG))  u5 (.opA(a4), .opB(b4), .carryIn(c4), .sumOut(sB4), .carryOut(oB4));
  ppAdder #(.N(8),  .TOPO(TOPO_KOGGE_STONE)) u6 (.opA(a8), .opB(b8), .carryIn(c8), .sumOut(sK8), .carryOut(oK8));
  ppAdder #(.N(8),  .TOPO(TOPO_SKLANSKY))    u7 (.opA(a8), .opB(b8), .carryIn(c8), .sumOut(sS8), .carryOut(oS8));
  ppAdder #(.N(8),  .TOPO(TOPO_BRENT_KUNG))  u8 (.opA(a8), .opB(b8), .carryIn(c8), .sumOut(sB8), .carryOut(oB8));

  task automatic cmp(input string req, input string who, input logic [32:0] got, input logic [32:0] exp);
    checksRun++;
    if (got !== exp) begin
      checksFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, who, got, exp);
    end
  endtask

  // Drive the wide operands, wait half a clock, compare all three shapes.
  task automatic applyWide(input string sumReq, input logic [31:0] a, input logic [31:0] b, input logic c,
                           input logic [32:0] expTotal);
    a32 = a; b32 = b; c32 = c;
    #2;
    cmp(sumReq, "u0 sum", {1'b0, sK32}, {1'b0, expTotal[31:0]});
    cmp(sumReq, "u1 sum", {1'b0, sS32}, {1'b0, expTotal[31:0]});
    cmp(sumReq, "u2 sum", {1'b0, sB32}, {1'b0, expTotal[31:0]});
    cmp("R2", "u0 cout", {32'd0, oK32}, {32'd0, expTotal[32]});
    cmp("R2", "u1 cout", {32'd0, oS32}, {32'd0, expTotal[32]});
    cmp("R2", "u2 cout", {32'd0, oB32}, {32'd0, expTotal[32]});
    #2;
  endtask

  task automatic testZeroInputs;  // R8
    applyWide("R8", 32'd0, 32'd0, 1'b0, 33'd0);
  endtask

  task automatic testCarryInOnly;  // R3
    applyWide("R3", 32'd0, 32'd0, 1'b1, 33'd1);
  endtask

  task automatic testAllPropagate;  // R4: complement operands
    logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_8765};
    foreach (pats[k]) begin
      applyWide("R4", pats[k], ~pats[k], 1'b0, {1'b0, 32'hFFFF_FFFF});
      applyWide("R4", pats[k], ~pats[k], 1'b1, {1'b1, 32'h0000_0000});
    end
  endtask

  task automatic testAllGenerate;  // R5
    applyWide("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, {1'b1, 32'hFFFF_FFFE});
    applyWide("R5", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, {1'b1, 32'hFFFF_FFFF});
  endtask

  task automatic testRandomWide;  // R1, R2, R6
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic        c;
      a = $urandom;
      b = $urandom;
      c = 1'($urandom);
      if (k % 4 == 1) b = ~a;
      applyWide("R1/R6", a, b, c, {1'b0, a} + {1'b0, b} + {32'd0, c});
    end
  endtask

  task automatic testExhaustive4;  // R7
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [4:0] exp;
          a4 = 4'(a); b4 = 4'(b); c4 = 1'(c);
          exp = 5'(a + b + c);
          #2;
          cmp("R7", "u3 N4", {28'd0, oK4, sK4}, {28'd0, exp});
          cmp("R7", "u4 N4", {28'd0, oS4, sS4}, {28'd0, exp});
          cmp("R7", "u5 N4", {28'd0, oB4, sB4}, {28'd0, exp});
          #2;
        end
      end
    end
  endtask

  task automatic testExhaustive8;  // R7
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [8:0] exp;
          a8 = 8'(a); b8 = 8'(b); c8 = 1'(c);
          exp = 9'(a + b + c);
          #2;
          cmp("R7", "u6 N8", {24'd0, oK8, sK8}, {24'd0, exp});
          cmp("R7", "u7 N8", {24'd0, oS8, sS8}, {24'd0, exp});
          cmp("R7", "u8 N8", {24'd0, oB8, sB8}, {24'd0, exp});
          #2;
        end
      end
    end
  endtask

  initial begin
    a32 = '0; b32 = '0; c32 = 1'b0;
    a4 = '0; b4 = '0; c4 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    testZeroInputs();
    testCarryInOnly();
    testAllPropagate();
    testAllGenerate();
    testRandomWide();
    testExhaustive4();
    testExhaustive8();
    $display("%0d/%0d checks passed", checksRun - checksFail, checksRun);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checksRun++;
    checksFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checksRun - checksFail, checksRun);
    $finish;
  end
endmodule